// File: doc/BRIEF.md
# Scrolling tile map address generator

This block turns the position of a background tile fetch into the linear address of its entry in a tile map of 40 columns by 30 rows, stored row-major in 1200 locations. The fetch sequencer supplies the scrolled display line (the halved display line already offset by the vertical scroll), the horizontal scroll value and the index of the tile being fetched within the current row. One clock later the block presents the map address that the map memory needs.

Scrolling in both directions wraps around the map. A line number that runs past the last map row starts again at the top, and a column that runs past the right edge starts again at column 0. Only whole-tile horizontal scroll is handled here. The three low bits of the horizontal scroll select a pixel offset inside a tile, and a separate display-delay stage applies them. The three low bits of the line number select a line inside the tile and are left to the pattern fetch.

Top module: `tmap_addr_gen`

## Requirements
- R1: While rst_ni is low, addr_o is 0.
- R2: addr_o is registered with one clock of latency. It takes the value computed from the inputs sampled at the previous rising edge of clk_i, and it holds between edges.
- R3: addr_o equals row * 40 + col, where row is the tile row and col is the tile column.
- R4: The tile row is line_i[7:3]. line_i[2:0] has no effect on addr_o.
- R5: When line_i[7:3] is 30 or 31, the tile row is 0 or 1 respectively. Line numbers 240 to 255 therefore address the first two map rows.
- R6: The tile column is (tile_idx_i + xscroll_i[8:3]) mod 40. The horizontal scroll wraps from column 39 back to column 0.
- R7: xscroll_i[2:0] has no effect on addr_o.
- R8: For every tile_idx_i from 0 to 39 and every value of line_i and xscroll_i, addr_o stays in the range 0 to 1199.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 8 | Scrolled display line number |
| xscroll_i | input | 9 | Horizontal scroll in pixels |
| tile_idx_i | input | 6 | Index of the fetched tile within the row, 0 to 39 |
| addr_o | output | 11 | Registered row-major map address |

## Verification
The bench goes after both wrap seams. Line numbers 232 to 255 cross the bottom of the map. A design that misses the vertical wrap emits addresses of 1200 or more, and a design that wraps at a power of two lands in the wrong row. Scroll values from 0 up to the largest coarse scroll of 63 are combined with every tile index, so that sums from 39 to 102 reach both the single and the double reduction modulo 40. An adder that wraps at 64, or that subtracts only once, produces columns past 39 that bleed into the next row. Random values in the low bits of the line and the scroll expose any leak of fine-pixel bits into the address, and sampling just before each edge catches a missing or doubled register stage.

// File: rtl/tmap_pkg.sv
package tmap_pkg;
  localparam int unsigned MAP_COLS    = 40;
  localparam int unsigned MAP_ROWS    = 30;
  localparam int unsigned TILE_SHIFT  = 3;
  localparam int unsigned LINE_W      = 8;
  localparam int unsigned XSCROLL_W   = 9;
  localparam int unsigned IDX_W       = 6;

  // number of binary-weighted subtract stages so that cols * 2**n exceeds max_val
  function automatic int unsigned mod_stages(input int unsigned max_val, input int unsigned cols);
    int unsigned n;
    n = 0;
    while ((cols << n) <= max_val) n++;
    return n;
  endfunction
endpackage

// File: rtl/tmap_row_wrap.sv
module tmap_row_wrap #(
  parameter int unsigned LINE_W     = tmap_pkg::LINE_W,
  parameter int unsigned TILE_SHIFT = tmap_pkg::TILE_SHIFT,
  parameter int unsigned MAP_ROWS   = tmap_pkg::MAP_ROWS,
  localparam int unsigned ROW_W     = LINE_W - TILE_SHIFT
) (
  input  logic [LINE_W-1:0] line_i,
  output logic [ROW_W-1:0]  row_o
);
  logic [ROW_W-1:0] row_raw;
  logic [TILE_SHIFT-1:0] unused_fine;

  assign row_raw     = line_i[LINE_W-1:TILE_SHIFT];
  assign unused_fine = line_i[TILE_SHIFT-1:0];

  // one subtract suffices while 2**ROW_W <= 2*MAP_ROWS
  always_comb begin
    if (row_raw >= ROW_W'(MAP_ROWS)) row_o = row_raw - ROW_W'(MAP_ROWS);
    else                             row_o = row_raw;
  end
endmodule

// File: rtl/tmap_col_wrap.sv
module tmap_col_wrap #(
  parameter int unsigned XSCROLL_W  = tmap_pkg::XSCROLL_W,
  parameter int unsigned TILE_SHIFT = tmap_pkg::TILE_SHIFT,
  parameter int unsigned IDX_W      = tmap_pkg::IDX_W,
  parameter int unsigned MAP_COLS   = tmap_pkg::MAP_COLS,
  localparam int unsigned XC_W      = XSCROLL_W - TILE_SHIFT,
  localparam int unsigned SUM_W     = ((XC_W > IDX_W) ? XC_W : IDX_W) + 1,
  localparam int unsigned SUM_MAX   = (2**IDX_W - 1) + (2**XC_W - 1),
  localparam int unsigned NSTG      = tmap_pkg::mod_stages(SUM_MAX, MAP_COLS),
  localparam int unsigned COL_W     = $clog2(MAP_COLS)
) (
  input  logic [XSCROLL_W-1:0] xscroll_i,
  input  logic [IDX_W-1:0]     tile_idx_i,
  output logic [COL_W-1:0]     col_o
);
  logic [SUM_W-1:0] stg [NSTG+1];
  logic [TILE_SHIFT-1:0] unused_fine;

  assign unused_fine = xscroll_i[TILE_SHIFT-1:0];
  assign stg[0] = SUM_W'(tile_idx_i) + SUM_W'(xscroll_i[XSCROLL_W-1:TILE_SHIFT]);

  // restoring reduction: subtract cols*2^k, largest weight first
  for (genvar k = 0; k < NSTG; k++) begin : g_red
    localparam int unsigned WT = MAP_COLS << (NSTG - 1 - k);
    always_comb begin
      if (stg[k] >= SUM_W'(WT)) stg[k+1] = stg[k] - SUM_W'(WT);
      else                      stg[k+1] = stg[k];
    end
  end

  assign col_o = COL_W'(stg[NSTG]);
endmodule

// File: rtl/tmap_addr_gen.sv
module tmap_addr_gen #(
  parameter int unsigned MAP_COLS   = tmap_pkg::MAP_COLS,
  parameter int unsigned MAP_ROWS   = tmap_pkg::MAP_ROWS,
  parameter int unsigned TILE_SHIFT = tmap_pkg::TILE_SHIFT,
  parameter int unsigned LINE_W     = tmap_pkg::LINE_W,
  parameter int unsigned XSCROLL_W  = tmap_pkg::XSCROLL_W,
  parameter int unsigned IDX_W      = tmap_pkg::IDX_W,
  localparam int unsigned ENTRIES   = MAP_COLS * MAP_ROWS,
  localparam int unsigned ADDR_W    = $clog2(ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LINE_W-1:0]    line_i,
  input  logic [XSCROLL_W-1:0] xscroll_i,
  input  logic [IDX_W-1:0]     tile_idx_i,
  output logic [ADDR_W-1:0]    addr_o
);
  localparam int unsigned ROW_W = LINE_W - TILE_SHIFT;
  localparam int unsigned COL_W = $clog2(MAP_COLS);

  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic [ADDR_W-1:0] addr_d;

  tmap_row_wrap #(
    .LINE_W(LINE_W), .TILE_SHIFT(TILE_SHIFT), .MAP_ROWS(MAP_ROWS)
  ) u_row (
    .line_i(line_i), .row_o(row)
  );

  tmap_col_wrap #(
    .XSCROLL_W(XSCROLL_W), .TILE_SHIFT(TILE_SHIFT), .IDX_W(IDX_W), .MAP_COLS(MAP_COLS)
  ) u_col (
    .xscroll_i(xscroll_i), .tile_idx_i(tile_idx_i), .col_o(col)
  );

  assign addr_d = ADDR_W'(row) * ADDR_W'(MAP_COLS) + ADDR_W'(col);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_o <= '0;
    else         addr_o <= addr_d;
  end

  // checker support: set after the first edge out of reset
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  // R5
  row_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row < ROW_W'(MAP_ROWS));

  // R6
  col_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col < COL_W'(MAP_COLS));

  // R8
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o < ADDR_W'(ENTRIES));

  // R2 R4 R7: unchanged coarse inputs leave the address unchanged
  coarse_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $stable(line_i[LINE_W-1:TILE_SHIFT])
               && $stable(xscroll_i[XSCROLL_W-1:TILE_SHIFT])
               && $stable(tile_idx_i)) |=> $stable(addr_o));

  // R1
  reset_val_chk: assert property (@(posedge clk_i)
    !rst_ni |-> addr_o == '0);
endmodule

// File: tb/tmap_addr_gen_bench.sv
module tmap_addr_gen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] line_i = '0;
  logic [8:0] xscroll_i = '0;
  logic [5:0] tile_idx_i = '0;
  logic [10:0] addr_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  tmap_addr_gen u_tmap_addr_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i),
    .xscroll_i(xscroll_i), .tile_idx_i(tile_idx_i), .addr_o(addr_o)
  );

  function automatic int ref_addr(int ln, int xs, int idx);
    int row, col;
    row = ln / 8;
    if (row >= 30) row = row - 30;
    col = (idx + xs / 8) % 40;
    return row * 40 + col;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d (line=%0d xs=%0d idx=%0d)",
               tag, act, exp, line_i, xscroll_i, tile_idx_i);
    end
  endtask

  // drive at negedge; check old value holds, then new value after the edge
  task automatic apply(string tag, int ln, int xs, int idx);
    int prev;
    @(negedge clk_i);
    prev = int'(addr_o);
    line_i = 8'(ln); xscroll_i = 9'(xs); tile_idx_i = 6'(idx);
    #1;
    chk("R2 hold", int'(addr_o), prev);
    @(negedge clk_i);
    chk(tag, int'(addr_o), ref_addr(ln, xs, idx));
    chk("R8 range", int'(addr_o < 11'd1200), 1);
  endtask

  initial begin
    int xs_set [6] = '{0, 8, 15, 256, 319, 511};
    int ln_set [6] = '{0, 7, 100, 239, 240, 255};
    int seed;
    line_i = 8'd200; xscroll_i = 9'd77; tile_idx_i = 6'd13;
    repeat (3) @(negedge clk_i);
    chk("R1 reset", int'(addr_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R2 first", int'(addr_o), ref_addr(200, 77, 13));

    // R3 R6: full tile sweep across scroll and line corners
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        for (int i = 0; i < 40; i++)
          apply("R3/R6 sweep", ln_set[b], xs_set[a], i);

    // R5: bottom seam
    apply("R5 row30", 240, 0, 0);
    chk("R5 row30 top", int'(addr_o), 0);
    apply("R5 row31", 255, 0, 39);
    chk("R5 row31", int'(addr_o), 79);
    apply("R5 row29", 239, 0, 39);
    chk("R5 row29", int'(addr_o), 1199);

    // R6: right seam and double reduction
    apply("R6 seam", 0, 8, 39);
    chk("R6 wrap0", int'(addr_o), 0);
    apply("R6 max", 0, 511, 39);
    chk("R6 dbl", int'(addr_o), 22);

    // R4 R7: fine bits must not move the address
    for (int f = 0; f < 8; f++) begin
      apply("R4 fine line", 80 + f, 40, 10);
      chk("R4 fine", int'(addr_o), 10 * 40 + 15);
      apply("R7 fine xs", 80, 40 + f, 10);
      chk("R7 fine", int'(addr_o), 10 * 40 + 15);
    end

    // random mix
    seed = $urandom(32'h5EED1);
    for (int n = 0; n < 3000; n++)
      apply("R3/R4/R5/R6/R7 rnd", int'($urandom % 256), int'($urandom % 512),
            int'($urandom % 40));

    // R1: reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 async", int'(addr_o), 0);
    @(negedge clk_i);
    chk("R1 held", int'(addr_o), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule